// File: doc/BRIEF.md
# Banked Program Address Generator

This block turns a 16-bit logical program counter into a 24-bit physical fetch address. The lower half of the logical space (PC bit 15 clear) is a common area that always maps to the bottom of physical memory. The upper half (PC bit 15 set) is a window onto whichever bank the code bank register currently selects.

Software never writes the code bank register directly. It writes a pending "next bank" register instead. That value moves into the code bank register only when a branch, call or return is actually taken. A conditional branch that falls through copies the current bank back into the pending register, so a bank change that was prepared but not used is discarded.

Two mode inputs select the variant:
- **Flat mode** passes the PC through unchanged.
- **Minimum mode** keeps the bank frozen.
- **Full banked mode** offers the current bank for pushing on calls and accepts a popped bank on returns.

Top module: `bank_fetch_addr`

## Requirements
- R1: With PC bit 15 = 0 in banked mode, address bits 22..15 are 00h and bits 14..0 equal PC[14:0], whatever the bank, so a PC that wraps from FFFFh to 0000h lands at physical address 000000h.
- R2: With PC bit 15 = 1 in banked mode, address bits 22..15 equal the code bank register and bits 14..0 equal PC[14:0].
- R3: Address bit 23 is always 0.
- R4: After reset, the code bank and next bank registers both hold 01h.
- R5: A next-bank write with no branch strobe changes only the next bank register. The code bank and the fetch address stay as they were.
- R6: In full banked mode, a taken branch or a call copies the next bank into the code bank at the clock edge. The new bank is visible on the address in the following cycle.
- R7: A not-taken branch copies the code bank into the next bank register.
- R8: In full banked mode, a return loads the popped bank into both the code bank and the next bank registers.
- R9: In full banked mode, the push-bank output shows the current code bank during the cycle of a call, before that call changes the bank.
- R10: In flat mode (banked_i = 0), the address is the 16-bit PC zero-extended, and the code bank never changes.
- R11: In minimum mode (max_mode_i = 0), taken branches, calls and returns leave the code bank unchanged, and the push-bank output reads 00h.
- R12: In full banked mode, simultaneous strobes resolve in this order: return first, then taken branch or call, then not-taken branch, then next-bank write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| banked_i | input | 1 | 1 selects banked address forming, 0 selects flat |
| max_mode_i | input | 1 | 1 selects full banked mode, 0 selects minimum mode |
| pc_i | input | 16 | Logical program counter |
| nb_wr_i | input | 1 | Write strobe for the next bank register |
| nb_wdata_i | input | 8 | Value written to the next bank register |
| taken_i | input | 1 | A branch is taken this cycle |
| not_taken_i | input | 1 | A conditional branch falls through this cycle |
| call_i | input | 1 | A call is taken this cycle |
| ret_i | input | 1 | A return is taken this cycle |
| pop_bank_i | input | 8 | Bank value popped from the stack on a return |
| fetch_addr_o | output | 24 | Physical fetch address |
| push_bank_o | output | 8 | Bank value to push with a call |
| next_bank_o | output | 8 | Current content of the next bank register |

## Verification
Addresses are tried with PC values on both sides of bit 15, including 0000h, 7FFFh, 8000h and FFFFh, under several bank values. This separates the common-area mapping from the windowed mapping and exercises the wrap to the start of memory. Strobe sequences cover a write followed by a taken branch, a not-taken branch and a call/return pair, and each shows whether the pending bank was committed or discarded. Repeating taken branches and returns in flat and minimum modes, and firing strobes together, distinguishes a frozen bank from a moving one and confirms the strobe ordering.

// File: rtl/bank_fetch_addr.sv
module bank_fetch_addr #(
  parameter int PC_W = 16,
  parameter int BANK_W = 8,
  parameter logic [BANK_W-1:0] RST_BANK = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     banked_i,
  input  logic                     max_mode_i,
  input  logic [PC_W-1:0]          pc_i,
  input  logic                     nb_wr_i,
  input  logic [BANK_W-1:0]        nb_wdata_i,
  input  logic                     taken_i,
  input  logic                     not_taken_i,
  input  logic                     call_i,
  input  logic                     ret_i,
  input  logic [BANK_W-1:0]        pop_bank_i,
  output logic [BANK_W+PC_W-1:0]   fetch_addr_o,
  output logic [BANK_W-1:0]        push_bank_o,
  output logic [BANK_W-1:0]        next_bank_o
);
  localparam int OFF_W = PC_W - 1;

  logic [BANK_W-1:0] cb_q, nb_q;
  logic              live;
  logic [BANK_W-1:0] page;

  assign live = banked_i & max_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_q <= RST_BANK;
      nb_q <= RST_BANK;
    end else if (live && ret_i) begin
      cb_q <= pop_bank_i;
      nb_q <= pop_bank_i;
    end else if (live && (taken_i || call_i)) begin
      cb_q <= nb_q;
    end else if (not_taken_i) begin
      nb_q <= cb_q;
    end else if (nb_wr_i) begin
      nb_q <= nb_wdata_i;
    end
  end

  assign page = pc_i[PC_W-1] ? cb_q : '0;

  assign fetch_addr_o = banked_i ? {1'b0, page, pc_i[OFF_W-1:0]}
                                 : {{BANK_W{1'b0}}, pc_i};
  assign push_bank_o  = live ? cb_q : '0;
  assign next_bank_o  = nb_q;
endmodule

module bank_fetch_addr_chk #(
  parameter int PC_W = 16,
  parameter int BANK_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   banked_i,
  input logic                   max_mode_i,
  input logic [PC_W-1:0]        pc_i,
  input logic                   nb_wr_i,
  input logic [BANK_W-1:0]      nb_wdata_i,
  input logic                   taken_i,
  input logic                   not_taken_i,
  input logic                   call_i,
  input logic                   ret_i,
  input logic [BANK_W-1:0]      pop_bank_i,
  input logic [BANK_W+PC_W-1:0] fetch_addr_o,
  input logic [BANK_W-1:0]      cb_q,
  input logic [BANK_W-1:0]      nb_q
);
  localparam int ADDR_W = BANK_W + PC_W;

  always_comb begin
    if (rst_n) a_r3_top_bit_zero: assert (fetch_addr_o[ADDR_W-1] == 1'b0);
  end

  a_r1_common_area: assert property (@(posedge clk) disable iff (!rst_n)
    (banked_i && !pc_i[PC_W-1]) |-> fetch_addr_o[ADDR_W-2:PC_W-1] == '0);

  a_r2_banked_window: assert property (@(posedge clk) disable iff (!rst_n)
    (banked_i && pc_i[PC_W-1]) |-> fetch_addr_o[ADDR_W-2:PC_W-1] == cb_q);

  a_r6_taken_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (banked_i && max_mode_i && !ret_i && (taken_i || call_i)) |=> cb_q == $past(nb_q));

  a_r7_fallthrough_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (not_taken_i && !((banked_i && max_mode_i) && (ret_i || taken_i || call_i)))
      |=> nb_q == $past(cb_q));

  a_r8_return_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (banked_i && max_mode_i && ret_i) |=> (cb_q == $past(pop_bank_i)) && (nb_q == $past(pop_bank_i)));

  a_r11_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(banked_i && max_mode_i) |=> $stable(cb_q));

  a_r5_write_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_wr_i && !taken_i && !not_taken_i && !call_i && !ret_i)
      |=> $stable(cb_q) && (nb_q == $past(nb_wdata_i)));
endmodule

bind bank_fetch_addr bank_fetch_addr_chk #(.PC_W(PC_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .banked_i(banked_i), .max_mode_i(max_mode_i),
  .pc_i(pc_i), .nb_wr_i(nb_wr_i), .nb_wdata_i(nb_wdata_i), .taken_i(taken_i),
  .not_taken_i(not_taken_i), .call_i(call_i), .ret_i(ret_i),
  .pop_bank_i(pop_bank_i), .fetch_addr_o(fetch_addr_o), .cb_q(cb_q), .nb_q(nb_q)
);

// File: tb/tb_bank_fetch_addr.sv
module tb_bank_fetch_addr;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        banked_i = 1, max_mode_i = 1;
  logic [15:0] pc_i = 0;
  logic        nb_wr_i = 0, taken_i = 0, not_taken_i = 0, call_i = 0, ret_i = 0;
  logic [7:0]  nb_wdata_i = 0, pop_bank_i = 0;
  logic [23:0] fetch_addr_o;
  logic [7:0]  push_bank_o, next_bank_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bank_fetch_addr dut (
    .clk(clk), .rst_n(rst_n), .banked_i(banked_i), .max_mode_i(max_mode_i),
    .pc_i(pc_i), .nb_wr_i(nb_wr_i), .nb_wdata_i(nb_wdata_i), .taken_i(taken_i),
    .not_taken_i(not_taken_i), .call_i(call_i), .ret_i(ret_i),
    .pop_bank_i(pop_bank_i), .fetch_addr_o(fetch_addr_o),
    .push_bank_o(push_bank_o), .next_bank_o(next_bank_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    nb_wr_i = 0; taken_i = 0; not_taken_i = 0; call_i = 0; ret_i = 0;
  endtask

  function automatic logic [23:0] win(input logic [7:0] b, input logic [15:0] pc);
    return {1'b0, (pc[15] ? b : 8'h00), pc[14:0]};
  endfunction

  task automatic set_addr_check(input string tag, input logic [15:0] pc, input logic [7:0] bank);
    pc_i = pc; #1;
    check(tag, fetch_addr_o, win(bank, pc));
    check({tag, " R3 top bit"}, fetch_addr_o[23], 0);
  endtask

  task automatic t_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1; #1;
    check("R4 next bank after reset", next_bank_o, 8'h01);
    check("R4 code bank after reset", push_bank_o, 8'h01);
    set_addr_check("R2 reset window", 16'h8123, 8'h01);
  endtask

  task automatic t_common();
    set_addr_check("R1 common 0000", 16'h0000, 8'h01);
    set_addr_check("R1 common 7FFF", 16'h7FFF, 8'h01);
  endtask

  task automatic t_write_only();
    pc_i = 16'h9000; nb_wdata_i = 8'h42; nb_wr_i = 1; tick();
    check("R5 pending written", next_bank_o, 8'h42);
    check("R5 bank unchanged", push_bank_o, 8'h01);
    check("R5 address unchanged", fetch_addr_o, win(8'h01, 16'h9000));
  endtask

  task automatic t_taken();
    taken_i = 1; tick();
    check("R6 taken commits", push_bank_o, 8'h42);
    set_addr_check("R2 FFFF window", 16'hFFFF, 8'h42);
    set_addr_check("R1 wrap to common", 16'h0000, 8'h42);
  endtask

  task automatic t_not_taken();
    nb_wdata_i = 8'h77; nb_wr_i = 1; tick();
    check("R5 pending 77", next_bank_o, 8'h77);
    not_taken_i = 1; tick();
    check("R7 pending restored", next_bank_o, 8'h42);
    check("R7 bank kept", push_bank_o, 8'h42);
  endtask

  task automatic t_call_ret();
    nb_wdata_i = 8'h10; nb_wr_i = 1; tick();
    call_i = 1; #1;
    check("R9 push bank at call", push_bank_o, 8'h42);
    tick();
    check("R6 call commits", push_bank_o, 8'h10);
    set_addr_check("R2 after call", 16'h8000, 8'h10);
    pop_bank_i = 8'h42; ret_i = 1; tick();
    check("R8 return code bank", push_bank_o, 8'h42);
    check("R8 return next bank", next_bank_o, 8'h42);
  endtask

  task automatic t_flat();
    banked_i = 0; pc_i = 16'hABCD; #1;
    check("R10 flat address", fetch_addr_o, 24'h00ABCD);
    nb_wdata_i = 8'h55; nb_wr_i = 1; tick();
    taken_i = 1; tick();
    banked_i = 1;
    set_addr_check("R10 bank held in flat", 16'h8000, 8'h42);
  endtask

  task automatic t_minimum();
    max_mode_i = 0; #1;
    check("R11 push bank zero", push_bank_o, 8'h00);
    taken_i = 1; tick();
    set_addr_check("R11 taken ignored", 16'h8000, 8'h42);
    pop_bank_i = 8'h99; ret_i = 1; tick();
    set_addr_check("R11 return ignored", 16'hC000, 8'h42);
    check("R11 next bank kept", next_bank_o, 8'h55);
    max_mode_i = 1;
  endtask

  task automatic t_priority();
    pop_bank_i = 8'h33; ret_i = 1; taken_i = 1; not_taken_i = 1; tick();
    check("R12 return wins bank", push_bank_o, 8'h33);
    check("R12 return wins pending", next_bank_o, 8'h33);
    nb_wdata_i = 8'h21; nb_wr_i = 1; tick();
    taken_i = 1; nb_wdata_i = 8'h66; nb_wr_i = 1; tick();
    check("R12 taken over write bank", push_bank_o, 8'h21);
    check("R12 taken over write pending", next_bank_o, 8'h21);
    nb_wdata_i = 8'h66; nb_wr_i = 1; tick();
    not_taken_i = 1; nb_wdata_i = 8'h70; nb_wr_i = 1; tick();
    check("R12 fallthrough over write", next_bank_o, 8'h21);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_common();
    t_write_only();
    t_taken();
    t_not_taken();
    t_call_ret();
    t_flat();
    t_minimum();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule